// File: doc/BRIEF.md
# Reset Sequencer with Selectable Start-up Delay

This block merges three reset requests into the single internal reset of a small controller: a power-on request, an external reset pin that has already been synchronized to the CPU clock, and a one-cycle watchdog time-out. The internal reset goes high at once, with no clock edge, whenever any request is active. Once every request has gone away, the block keeps the reset high for a start-up delay chosen by a 2-bit select. The delay is either five CPU clock cycles or a fixed number of slow-oscillator cycles. Each slow-oscillator cycle reaches the block as a one-cycle `slow_tick` enable in the CPU clock domain. The oscillator itself and the analog power-on detector are outside this block.

The core is a three-state machine. In HOLD a request is active and the delay counter is cleared. In DELAY the counter advances on each qualifying tick. In RUN the internal reset is released. The transitions are as follows. Any request forces HOLD, and the power-on request does so asynchronously. HOLD moves to DELAY at the first edge that samples no request. DELAY moves to RUN on the edge that counts the final tick. RUN stays in RUN until a request arrives. The block also keeps two sticky cause flags, power-on and external. Software clears either flag by writing a zero to its bit.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_req` is high, `rst_out` is high with no clock needed, `flag_por` reads 1 and `flag_ext` reads 0.
- R2: While `ext_rst_n` is low, or in the cycle where `wdt_timeout` is high, `rst_out` is high and the delay counter is held at zero.
- R3: With `startup_sel` = 00, `rst_out` falls on the 5th rising edge after the first edge that samples no request, and `slow_tick` has no effect.
- R4: With `startup_sel` = 01, 10 or 11, `rst_out` falls on the edge that samples the 512th, 4096th or 16384th `slow_tick` pulse respectively. Counting starts at the edge after the first request-free edge, so a tick sampled at that first request-free edge does not count.
- R5: A watchdog time-out is a one-cycle high pulse on `wdt_timeout`. The delay starts from its falling edge, with the same counts as R3 and R4.
- R6: A request that arrives during the delay restarts the delay from zero once that request is gone.
- R7: `flag_por` is set only by `por_req`. External and watchdog resets leave it unchanged.
- R8: `flag_ext` is set on every edge where `ext_rst_n` is low. Watchdog resets leave it unchanged.
- R9: A write (`flag_wr` high) clears `flag_por` at the next edge if `flag_wdata` bit 0 is 0, and clears `flag_ext` if bit 1 is 0. A bit written as 1 leaves its flag unchanged. If an external request and a clear of `flag_ext` come in the same cycle, the set wins.
- R10: After the delay has run out, `rst_out` stays low for as long as no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| ext_rst_n | input | 1 | Synchronized reset pin, low requests reset |
| wdt_timeout | input | 1 | One-cycle watchdog time-out pulse |
| startup_sel | input | 2 | Start-up delay select (00 = 5 clocks, 01/10/11 = 512/4096/16384 ticks) |
| slow_tick | input | 1 | One-cycle enable marking each slow-oscillator cycle |
| flag_wr | input | 1 | Write strobe for the cause flags |
| flag_wdata | input | 2 | Write data: bit 0 is the power-on flag, bit 1 is the external flag; 0 clears |
| rst_out | output | 1 | Internal reset, active high |
| flag_por | output | 1 | Power-on cause flag |
| flag_ext | output | 1 | External cause flag |

## Verification
The bench sweeps every start-up select with both an external and a watchdog release. It drives a tick pattern with gaps and counts the qualifying ticks itself, edge by edge. A design that counted the tick sampled at the release edge, or that was off by one at the terminal count, would release one tick early or late, and the bench would catch the edge where that happens. The bench drives ticks under select 00 as well, so a design that let the slow oscillator affect the fast delay would release too early. Other scenarios fire a watchdog pulse part-way through a delay, raise a set and a clear of the external flag in the same cycle, and raise a power-on request asynchronously between edges. A design that failed to restart the counter, let the clear win over the set, or waited for a clock edge to assert reset would show a wrong level on the port.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    localparam int FLAG_BIT_POR = 0;
    localparam int FLAG_BIT_EXT = 1;
endpackage

// File: rtl/rstseq_delay_cnt.sv
module rstseq_delay_cnt #(
    parameter int LIM_FAST  = 5,
    parameter int LIM_SLOW1 = 512,
    parameter int LIM_SLOW2 = 4096,
    parameter int LIM_SLOW3 = 16384,
    parameter int CNT_W     = 15
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       cnt_clr,
    input  logic       cnt_en,
    input  logic [1:0] startup_sel,
    input  logic       slow_tick,
    output logic       cnt_done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             tick_eff;
    logic             adv;

    always_comb begin
        unique case (startup_sel)
            2'b00:   lim = CNT_W'(LIM_FAST);
            2'b01:   lim = CNT_W'(LIM_SLOW1);
            2'b10:   lim = CNT_W'(LIM_SLOW2);
            default: lim = CNT_W'(LIM_SLOW3);
        endcase
    end

    assign tick_eff = (startup_sel == 2'b00) ? 1'b1 : slow_tick;
    assign adv      = cnt_en & tick_eff;
    assign cnt_done = adv & (cnt_q == (lim - CNT_W'(1)));

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req)
            cnt_q <= '0;
        else if (cnt_clr)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2: a cleared counter starts from zero on the next cycle
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (por_req)
        cnt_clr |=> (cnt_q == '0));

    // R4: a slow select with no tick leaves the count untouched
    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (por_req)
        (!cnt_clr && startup_sel != 2'b00 && !slow_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic clk,
    input  logic por_req,
    input  logic sync_req,
    input  logic cnt_done,
    output logic cnt_clr,
    output logic cnt_en,
    output logic seq_busy
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sync_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_DELAY;
                ST_DELAY: if (cnt_done) state_d = ST_RUN;
                ST_RUN:   state_d = ST_RUN;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        cnt_clr  = (state_q != ST_DELAY);
        cnt_en   = (state_q == ST_DELAY);
        seq_busy = (state_q != ST_RUN);
    end

    // R2: any synchronous request lands the machine in HOLD
    p_req_holds_r2: assert property (@(posedge clk) disable iff (por_req)
        sync_req |=> (state_q == ST_HOLD));

    // R3: RUN is reached only from DELAY on the terminal count
    p_run_entry_r3: assert property (@(posedge clk) disable iff (por_req)
        (state_q != ST_RUN) ##1 (state_q == ST_RUN) |-> $past(cnt_done));

    // R10: RUN is left only when a request arrives
    p_run_stays_r10: assert property (@(posedge clk) disable iff (por_req)
        (state_q == ST_RUN && !sync_req) |=> (state_q == ST_RUN));
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic       clk,
    input  logic       por_req,
    input  logic       ext_rst_n,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    output logic       flag_por,
    output logic       flag_ext
);
    logic por_q, ext_q;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            por_q <= 1'b1;
            ext_q <= 1'b0;
        end else begin
            if (!ext_rst_n)
                ext_q <= 1'b1;
            else if (flag_wr && !flag_wdata[FLAG_BIT_EXT])
                ext_q <= 1'b0;
            if (flag_wr && !flag_wdata[FLAG_BIT_POR])
                por_q <= 1'b0;
        end
    end

    assign flag_por = por_q;
    assign flag_ext = ext_q;

    // R8: the external request sets its flag even against a clear
    p_ext_sets_r8: assert property (@(posedge clk) disable iff (por_req)
        !ext_rst_n |=> ext_q);

    // R7: without a clearing write the power-on flag holds
    p_por_sticky_r7: assert property (@(posedge clk) disable iff (por_req)
        (!flag_wr || flag_wdata[FLAG_BIT_POR]) |=> $stable(por_q));

    // R9: with no external request and no clear, the external flag holds
    p_ext_sticky_r9: assert property (@(posedge clk) disable iff (por_req)
        (ext_rst_n && (!flag_wr || flag_wdata[FLAG_BIT_EXT])) |=> $stable(ext_q));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int LIM_FAST  = 5,
    parameter int LIM_SLOW1 = 512,
    parameter int LIM_SLOW2 = 4096,
    parameter int LIM_SLOW3 = 16384
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       ext_rst_n,
    input  logic       wdt_timeout,
    input  logic [1:0] startup_sel,
    input  logic       slow_tick,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    output logic       rst_out,
    output logic       flag_por,
    output logic       flag_ext
);
    localparam int CNT_RAW = $clog2(LIM_SLOW3 + 1);
    localparam int CNT_W   = (CNT_RAW < 14) ? 14 : CNT_RAW;

    logic sync_req;
    logic cnt_clr, cnt_en, cnt_done, seq_busy;

    assign sync_req = ~ext_rst_n | wdt_timeout;

    rstseq_fsm u_fsm (
        .clk      (clk),
        .por_req  (por_req),
        .sync_req (sync_req),
        .cnt_done (cnt_done),
        .cnt_clr  (cnt_clr),
        .cnt_en   (cnt_en),
        .seq_busy (seq_busy)
    );

    rstseq_delay_cnt #(
        .LIM_FAST  (LIM_FAST),
        .LIM_SLOW1 (LIM_SLOW1),
        .LIM_SLOW2 (LIM_SLOW2),
        .LIM_SLOW3 (LIM_SLOW3),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .por_req     (por_req),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .startup_sel (startup_sel),
        .slow_tick   (slow_tick),
        .cnt_done    (cnt_done)
    );

    rstseq_cause u_cause (
        .clk        (clk),
        .por_req    (por_req),
        .ext_rst_n  (ext_rst_n),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .flag_por   (flag_por),
        .flag_ext   (flag_ext)
    );

    assign rst_out = por_req | sync_req | seq_busy;

    // R5: the cycle after a watchdog pulse still holds reset
    p_wdt_stretch_r5: assert property (@(posedge clk) disable iff (por_req)
        wdt_timeout |=> rst_out);
endmodule

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
    logic       clk = 1'b0;
    logic       por_req, ext_rst_n, wdt_timeout, slow_tick, flag_wr;
    logic [1:0] startup_sel, flag_wdata;
    logic       rst_out, flag_por, flag_ext;

    int n_tests = 0;
    int n_fail  = 0;
    int phase   = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    reset_sequencer dut (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
        .startup_sel(startup_sel), .slow_tick(slow_tick), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .rst_out(rst_out), .flag_por(flag_por), .flag_ext(flag_ext)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!cond) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input int sel);
        case (sel)
            0: return 5;
            1: return 512;
            2: return 4096;
            default: return 16384;
        endcase
    endfunction

    // Called at a negedge just after the last request was removed.
    task automatic run_delay(input int sel, input string req);
        int  n, mcnt, bad_at, bad_act;
        bit  first;
        logic t;
        n = lim_of(sel);
        mcnt = 0; first = 1; bad_at = -1; bad_act = 0;
        for (int guard = 0; guard < 4 * n + 40 && mcnt < n; guard++) begin
            t = ((phase % 3) != 0);
            phase = phase + 1;
            slow_tick = t;
            @(posedge clk);
            if (!first && (sel == 0 || t)) mcnt = mcnt + 1;
            first = 0;
            @(negedge clk);
            if (bad_at < 0 && rst_out !== (mcnt < n)) begin
                bad_at = mcnt; bad_act = rst_out;
            end
        end
        chk(bad_at < 0 && mcnt == n, req, bad_act, (bad_at < n) ? 1 : 0);
        bad_at = -1;
        for (int k = 0; k < 4; k++) begin
            slow_tick = ((phase % 3) != 0);
            phase = phase + 1;
            @(negedge clk);
            if (rst_out !== 1'b0) bad_at = k;
        end
        chk(bad_at < 0, "R10 stays released", rst_out, 0);
        slow_tick = 1'b0;
    endtask

    task automatic ext_pulse(input int len);
        ext_rst_n = 1'b0;
        repeat (len) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic wdt_pulse();
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
    endtask

    task automatic wr_flags(input logic [1:0] d);
        flag_wr = 1'b1; flag_wdata = d;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 2'b11;
    endtask

    initial begin
        por_req = 1'b1; ext_rst_n = 1'b1; wdt_timeout = 1'b0; slow_tick = 1'b0;
        flag_wr = 1'b0; flag_wdata = 2'b11; startup_sel = 2'b00;
        repeat (3) @(negedge clk);
        chk(rst_out === 1'b1, "R1 reset during power-on", rst_out, 1);
        chk(flag_por === 1'b1, "R1 por flag after power-on", flag_por, 1);
        chk(flag_ext === 1'b0, "R1 ext flag after power-on", flag_ext, 0);
        por_req = 1'b0;
        run_delay(0, "R3 release after power-on");
        chk(flag_por === 1'b1 && flag_ext === 1'b0, "R7 flags after power-on run", {flag_por, flag_ext}, 2);

        wr_flags(2'b10);
        chk(flag_por === 1'b0, "R9 clear por flag", flag_por, 0);

        ext_pulse(3);
        run_delay(0, "R3 ext release sel 00");
        chk(flag_ext === 1'b1 && flag_por === 1'b0, "R8 R7 ext sets only ext flag",
            {flag_por, flag_ext}, 1);
        wr_flags(2'b11);
        chk(flag_ext === 1'b1, "R9 writing ones leaves flag", flag_ext, 1);
        wr_flags(2'b01);
        chk(flag_ext === 1'b0, "R9 clear ext flag", flag_ext, 0);

        for (int sel = 0; sel < 4; sel++) begin
            startup_sel = 2'(sel);
            ext_pulse(2);
            run_delay(sel, (sel == 0) ? "R3 ext sweep" : "R4 ext sweep");
            wr_flags(2'b01);
            wdt_pulse();
            run_delay(sel, "R5 watchdog sweep");
            chk(flag_ext === 1'b0 && flag_por === 1'b0, "R8 R7 watchdog leaves flags",
                {flag_por, flag_ext}, 0);
        end

        startup_sel = 2'b01;
        ext_pulse(2);
        for (int k = 0; k < 300; k++) begin
            slow_tick = ((phase % 3) != 0);
            phase = phase + 1;
            @(negedge clk);
        end
        slow_tick = 1'b0;
        chk(rst_out === 1'b1, "R6 reset held mid-delay", rst_out, 1);
        wdt_pulse();
        run_delay(1, "R6 restart after mid-delay watchdog");

        wr_flags(2'b01);
        ext_rst_n = 1'b0; flag_wr = 1'b1; flag_wdata = 2'b00;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 2'b11; ext_rst_n = 1'b1;
        chk(flag_ext === 1'b1, "R9 set wins over clear", flag_ext, 1);
        chk(flag_por === 1'b0, "R9 por cleared by same write", flag_por, 0);
        run_delay(1, "R4 release after set-clear");

        #1 por_req = 1'b1;
        #0.5;
        chk(rst_out === 1'b1, "R1 async assertion", rst_out, 1);
        chk(flag_por === 1'b1 && flag_ext === 1'b0, "R1 flags on async power-on",
            {flag_por, flag_ext}, 2);
        @(negedge clk);
        por_req = 1'b0;
        run_delay(1, "R4 release after power-on sel 01");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule